// File: doc/BRIEF.md
# Double-Buffered Job Loader with Result Readback

This block sits between a host port and a scanning engine. It holds two job buffers of nineteen 32-bit words each. The scanner works from the active buffer. The host writes the next job one word at a time. Every host write goes to whichever buffer is not active, so the host never has to name a buffer. When the inactive buffer holds a complete job, a swap request makes it the active one. The other buffer then becomes the target for later writes.

The scanner reports each result as a 32-bit word. Results go into a 16-slot circular store. The host follows the write pointer to find new entries. It retires entries one at a time with an acknowledge. If a result arrives while all 16 slots are unread, it is thrown away and counted.

A single registered read port serves the host. Its address map is:
- The lowest addresses read the result slots.
- The next addresses read the tail words of the active job.
- Every remaining address returns the scan-chain data input.

Top module: `job_bank_ctrl`

## Requirements
- R1: After a synchronous reset, `active_job` is 0, `nonce_wptr` is 0, `drop_count` is 0, and every buffer word and result slot reads back as 0.
- R2: A write with `wr_en` high and `wr_addr` below 19 stores `wr_data` in the buffer that is not active. The words of the active job, read at addresses 16 to 18, are unchanged by it.
- R3: `swap_req` takes effect only when all 19 words of the inactive buffer have been written since the last swap. A request before then leaves `active_job` and the active job's readback unchanged.
- R4: An accepted swap inverts `active_job` on the next clock edge. From then on, addresses 16 to 18 return words 16 to 18 of the newly loaded job. The written-word tracking restarts, so another 19 writes are needed before the next swap.
- R5: A write with `wr_addr` of 19 or more is ignored. It stores nothing and does not count toward a complete load.
- R6: Each accepted result is stored in slot `nonce_wptr`, and `nonce_wptr` then advances by one, wrapping from 15 to 0.
- R7: Read addresses 0 to 15 return the result slot with that index.
- R8: Read addresses 19 to 31 return the value `scan_in` had in the cycle the address was presented.
- R9: A result that arrives while 16 results are unread is dropped. No slot changes, `nonce_wptr` holds, and `drop_count` increments by one.
- R10: `nonce_ack` retires one unread result and frees a slot for the next arrival. An acknowledge while no result is unread has no effect.
- R11: `rd_data` is registered. It reflects the `rd_addr` sampled at one clock edge and is valid after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host job-word write strobe |
| wr_addr | input | 5 | Word index within the job (0 to 18 valid) |
| wr_data | input | 32 | Job word to store |
| swap_req | input | 1 | Request to make the loaded buffer active |
| nonce_valid | input | 1 | Scanner presents a result |
| nonce_data | input | 32 | Result word |
| nonce_ack | input | 1 | Host retires one unread result |
| rd_addr | input | 5 | Host readback address |
| scan_in | input | 32 | Scan-chain data routed to unmapped read addresses |
| rd_data | output | 32 | Registered readback word |
| active_job | output | 1 | Index of the buffer being scanned |
| nonce_wptr | output | 4 | Slot that the next accepted result will fill |
| drop_count | output | 8 | Number of results lost to a full store |

## Verification
Each state change appears one edge after its stimulus:
- A job-word write, a swap decision, a stored result, a pointer step and a drop count are all visible at the edge that samples the input.
- Readback adds one more register stage. The bench drives every input at the falling edge, so a write and a following read of that word show up two falling edges later.

The bench samples every output at a falling edge, half a period away from the clock edge that updates it. Reads of the result slots are made only after the pushes that fill them have landed. The swap and drop cases are arranged so that the accepting or refusing edge is the only edge between stimulus and check.

// File: rtl/job_pkg.sv
package job_pkg;
  typedef enum logic [1:0] {
    SRC_NONCE = 2'd0,
    SRC_JOB   = 2'd1,
    SRC_SCAN  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/job_bank.sv
module job_bank #(
  parameter int WORD_W    = 32,
  parameter int JOB_WORDS = 19,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              swap_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              active,
  output logic [WORD_W-1:0] rd_word
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(JOB_WORDS);

  logic [JOB_WORDS-1:0] filled_q;
  logic                 act_q;
  logic                 swap_go;
  logic                 wr_ok;
  logic [ADDR_W-1:0]    rd_idx;
  logic [WORD_W-1:0]    buf_rd [2];

  assign swap_go = swap_req && (&filled_q);
  // a write in the cycle of an accepted swap is discarded
  assign wr_ok   = wr_en && (wr_addr < LIMIT) && !swap_go;
  assign rd_idx  = (rd_addr < LIMIT) ? rd_addr : '0;

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic [WORD_W-1:0] words [JOB_WORDS];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < JOB_WORDS; i++) words[i] <= '0;
      end else if (wr_ok && (act_q != 1'(b))) begin
        words[wr_addr] <= wr_data;
      end
    end
    assign buf_rd[b] = words[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      filled_q <= '0;
    end else if (swap_go) begin
      act_q    <= ~act_q;
      filled_q <= '0;
    end else if (wr_ok) begin
      filled_q[wr_addr] <= 1'b1;
    end
  end

  assign active  = act_q;
  assign rd_word = buf_rd[act_q];

  AST_SWAP_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    (act_q != $past(act_q)) |-> $past(swap_req && (&filled_q))); // R3
  AST_SWAP_TAKES: assert property (@(posedge clk) disable iff (rst)
    (swap_req && (&filled_q)) |=> (act_q != $past(act_q))); // R4
endmodule

// File: rtl/nonce_ring.sv
module nonce_ring #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  parameter int DROP_W = 8,
  parameter int PW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              ack,
  input  logic [PW-1:0]     rd_idx,
  output logic [PW-1:0]     wptr,
  output logic [WORD_W-1:0] rd_word,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WORD_W-1:0] slots [DEPTH];
  logic [PW-1:0]     wptr_q;
  logic [CW-1:0]     count_q;
  logic [DROP_W-1:0] drop_q;
  logic              full, accept, take;

  assign full   = (count_q == FULL_CNT);
  assign accept = push && !full;
  assign take   = ack && (count_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (accept) begin
      slots[wptr_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      count_q <= '0;
      drop_q  <= '0;
    end else begin
      if (accept) wptr_q <= wptr_q + PW'(1);
      count_q <= count_q + CW'(accept) - CW'(take);
      if (push && full) drop_q <= drop_q + DROP_W'(1);
    end
  end

  assign wptr     = wptr_q;
  assign rd_word  = slots[rd_idx];
  assign drop_cnt = drop_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count_q <= FULL_CNT); // R9
  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    (drop_q != $past(drop_q)) |-> $past(push && full)); // R9
  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (wptr_q != $past(wptr_q)) |-> ($past(push) && wptr_q == $past(wptr_q) + PW'(1))); // R6
endmodule

// File: rtl/job_bank_ctrl.sv
module job_bank_ctrl #(
  parameter int WORD_W      = 32,
  parameter int JOB_WORDS   = 19,
  parameter int NONCE_DEPTH = 16,
  parameter int DROP_W      = 8,
  parameter int ADDR_W      = $clog2(JOB_WORDS),
  parameter int PW          = $clog2(NONCE_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              swap_req,
  input  logic              nonce_valid,
  input  logic [WORD_W-1:0] nonce_data,
  input  logic              nonce_ack,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] scan_in,
  output logic [WORD_W-1:0] rd_data,
  output logic              active_job,
  output logic [PW-1:0]     nonce_wptr,
  output logic [DROP_W-1:0] drop_count
);
  import job_pkg::*;

  localparam logic [ADDR_W-1:0] NONCE_LIM = ADDR_W'(NONCE_DEPTH);
  localparam logic [ADDR_W-1:0] JOB_LIM   = ADDR_W'(JOB_WORDS);

  logic [WORD_W-1:0] job_word, nonce_word, rd_q;
  rd_src_e           src;

  job_bank #(.WORD_W(WORD_W), .JOB_WORDS(JOB_WORDS), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .swap_req(swap_req), .rd_addr(rd_addr), .active(active_job), .rd_word(job_word)
  );

  nonce_ring #(.WORD_W(WORD_W), .DEPTH(NONCE_DEPTH), .DROP_W(DROP_W), .PW(PW)) u_ring (
    .clk(clk), .rst(rst), .push(nonce_valid), .push_data(nonce_data), .ack(nonce_ack),
    .rd_idx(rd_addr[PW-1:0]), .wptr(nonce_wptr), .rd_word(nonce_word), .drop_cnt(drop_count)
  );

  always_comb begin
    if (rd_addr < NONCE_LIM)    src = SRC_NONCE;
    else if (rd_addr < JOB_LIM) src = SRC_JOB;
    else                        src = SRC_SCAN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      unique case (src)
        SRC_NONCE: rd_q <= nonce_word;
        SRC_JOB:   rd_q <= job_word;
        default:   rd_q <= scan_in;
      endcase
    end
  end

  assign rd_data = rd_q;

  AST_SCAN_ROUTE: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) >= JOB_LIM && !$past(rst)) |-> (rd_data == $past(scan_in))); // R8
endmodule

// File: tb/job_bank_ctrl_tb.sv
module job_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, swap_req = 1'b0, nonce_valid = 1'b0, nonce_ack = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, nonce_data = '0, scan_in = '0;
  logic [31:0] rd_data;
  logic        active_job;
  logic [3:0]  nonce_wptr;
  logic [7:0]  drop_count;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] JA = 32'hA000_0000;
  localparam logic [31:0] JB = 32'hB000_0000;
  localparam logic [31:0] NB = 32'hC0DE_0000;
  localparam logic [31:0] SC = 32'h5CA4_0000;

  // read vectors: {rd_addr, expected rd_data}
  localparam logic [36:0] RD_VEC [8] = '{
    {5'd0,  NB + 32'd0}, {5'd1,  NB + 32'd1}, {5'd4,  NB + 32'd4},
    {5'd16, JB + 32'd16}, {5'd18, JB + 32'd18}, {5'd19, SC},
    {5'd20, SC}, {5'd31, SC}
  };

  always #2 clk = ~clk;

  job_bank_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .swap_req(swap_req), .nonce_valid(nonce_valid), .nonce_data(nonce_data),
    .nonce_ack(nonce_ack), .rd_addr(rd_addr), .scan_in(scan_in), .rd_data(rd_data),
    .active_job(active_job), .nonce_wptr(nonce_wptr), .drop_count(drop_count)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic write_word(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic swap();
    swap_req = 1'b1;
    cyc();
    swap_req = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    nonce_valid = 1'b1; nonce_data = d;
    cyc();
    nonce_valid = 1'b0;
  endtask

  task automatic ack();
    nonce_ack = 1'b1;
    cyc();
    nonce_ack = 1'b0;
  endtask

  task automatic read(input logic [4:0] a, output logic [31:0] d);
    rd_addr = a;
    cyc();
    d = rd_data;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R1 reset state
    check("R1 active", {31'b0, active_job}, 32'd0);
    check("R1 wptr", {28'b0, nonce_wptr}, 32'd0);
    check("R1 drop", {24'b0, drop_count}, 32'd0);
    read(5'd16, r); check("R1 job word", r, 32'd0);
    read(5'd0, r);  check("R1 slot", r, 32'd0);

    // partial load of buffer 1, plus out-of-range write (R5)
    for (int i = 0; i < 18; i++) write_word(5'(i), JA + 32'(i));
    write_word(5'd19, 32'hDEAD_BEEF);
    swap();
    check("R3 partial swap refused", {31'b0, active_job}, 32'd0);
    check("R5 addr 19 not counted", {31'b0, active_job}, 32'd0);
    read(5'd16, r); check("R2 active job untouched", r, 32'd0);

    // R11 one-cycle latency: address change visible after one edge
    rd_addr = 5'd20; scan_in = 32'h1234_5678;
    cyc();
    scan_in = 32'h0;
    check("R11 registered read", rd_data, 32'h1234_5678);

    write_word(5'd18, JA + 32'd18);
    swap();
    check("R4 swap accepted", {31'b0, active_job}, 32'd1);
    for (int i = 16; i < 19; i++) begin
      read(5'(i), r); check("R4 new job readback", r, JA + 32'(i));
    end

    // load buffer 0 while buffer 1 active
    for (int i = 0; i < 19; i++) write_word(5'(i), JB + 32'(i));
    read(5'd17, r); check("R2 write steered to inactive", r, JA + 32'd17);
    swap();
    check("R4 second swap", {31'b0, active_job}, 32'd0);
    swap();
    check("R4 tracking restarts", {31'b0, active_job}, 32'd0);

    // results
    for (int k = 0; k < 5; k++) push(NB + 32'(k));
    check("R6 wptr after 5", {28'b0, nonce_wptr}, 32'd5);
    scan_in = SC;
    foreach (RD_VEC[i]) begin
      read(RD_VEC[i][36:32], r);
      check("R7/R8 table read", r, RD_VEC[i][31:0]);
    end
    scan_in = '0;

    for (int k = 5; k < 16; k++) push(NB + 32'(k));
    check("R6 wptr wraps", {28'b0, nonce_wptr}, 32'd0);
    read(5'd15, r); check("R7 slot 15", r, NB + 32'd15);
    push(32'hBAD0_0001);
    check("R9 drop counted", {24'b0, drop_count}, 32'd1);
    check("R9 wptr held", {28'b0, nonce_wptr}, 32'd0);
    read(5'd0, r); check("R9 slot kept", r, NB);

    ack();
    push(32'hF00D_0000);
    check("R10 ack frees slot", {24'b0, drop_count}, 32'd1);
    check("R10 wptr", {28'b0, nonce_wptr}, 32'd1);
    read(5'd0, r); check("R10 slot refilled", r, 32'hF00D_0000);

    // retire all 16, then 4 extra acks on empty store
    for (int k = 0; k < 20; k++) ack();
    for (int k = 0; k < 17; k++) push(32'hE000_0000 + 32'(k));
    check("R10 empty ack ignored", {24'b0, drop_count}, 32'd2);
    check("R6 wptr after 16 more", {28'b0, nonce_wptr}, 32'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule